// File: doc/BRIEF.md
# Reloading Down-Counter / Timer Channel

This block is a single byte-programmed counting channel. Software configures it by writing bytes to one port. A byte with its lowest bit set is a control byte, which sets the interrupt enable, the counting source, the prescale ratio, the active input edge and the start condition. That control byte can announce that the next byte is a time constant. Reading the port returns the live value of the down-counter.

In event-counting mode, each selected edge of an asynchronous external input is synchronised and then decrements the counter. In timing mode, the system clock passes through a divide-by-16 or divide-by-256 prescaler, and each prescaler wrap decrements the counter. A timing channel starts right after its constant is written, or it waits for a selected edge on the same external input. Each time the count runs out, the channel reloads with no lost cycle, emits a one-cycle zero-count pulse, and strobes an interrupt request if interrupts are enabled. A constant written while the channel runs is held until the next reload.

Top module: `tmr_chan`

## Requirements
- R1: With no constant pending, a written byte with bit 0 = 1 is a control byte: bit 7 interrupt enable, bit 6 mode (1 = event counting, 0 = timing), bit 5 prescale (1 = divide by 256, 0 = divide by 16), bit 4 active edge (1 = rising, 0 = falling), bit 3 start (1 = wait for external edge, 0 = start on load), bit 2 constant follows, bit 1 stop. With no constant pending, a byte with bit 0 = 0 has no effect.
- R2: After a control byte with bit 2 set, the next byte written is taken as the time constant, whatever its bit 0, and the pending state then clears.
- R3: A constant byte of 0x00 means 256. The read port returns the low 8 bits of the counter, so 256 reads as 0x00. After reset it reads 0x00.
- R4: A decrement that takes the count from 1 reloads it with the constant. In the next cycle `zero_pulse` is high for exactly one cycle, and `irq_req` is high in that same cycle only if interrupt enable was set at the decrement.
- R5: A constant written while the channel runs does not change the count. It is used at the next reload. If the write lands in the cycle of the reload, the new value is loaded.
- R6: In event mode, a selected edge on `ext_in` that is first sampled at clock edge k decrements the count at clock edge k+2. Edges of the other polarity are ignored.
- R7: In timing mode, the count decrements once every 16 or 256 clocks, so `zero_pulse` repeats every prescale × constant clocks.
- R8: In timing mode with auto start, a constant accepted at edge w loads the count at w and gives the first decrement at edge w + prescale.
- R9: In timing mode with external start, the loaded count holds until a selected edge on `ext_in`. If that edge is first sampled at k, counting runs from k+2 and the first decrement falls at k+2+prescale.
- R10: A control byte with bit 1 set stops the channel at once, blocks a decrement in that same cycle and freezes the count. A later constant restarts the channel from the new value.
- R11: Until a constant has been accepted after reset, the channel produces no `zero_pulse`.
- R12: Reset clears the configuration (including interrupt enable), the count and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Control or constant byte |
| rd_data | output | 8 | Live down-counter value |
| ext_in | input | 1 | Asynchronous event / start input |
| zero_pulse | output | 1 | One-cycle pulse after each terminal count |
| irq_req | output | 1 | One-cycle interrupt request strobe |

## Verification
The deferred reload and the terminal count can fall in the same clock: the byte that completes a constant can arrive on the edge where the count leaves 1. The bench provokes this with a constant of 1 in divide-by-16 timing. It locks onto a zero-count pulse and times the new constant byte to land sixteen edges later, exactly on the next reload. It then expects the new value, not the old one, to read back on that edge. A behavioural model runs alongside for every clock and also covers a stop command meeting a decrement, where the stop wins.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = BYTE_W + 1;
    localparam int DIV_SHORT = 16;
    localparam int DIV_LONG  = 256;
    localparam int PRE_W     = $clog2(DIV_LONG);

    // Control byte bit positions (decoded by software-visible behaviour)
    localparam int B_CTRL   = 0;
    localparam int B_HALT   = 1;
    localparam int B_FOLLOW = 2;
    localparam int B_TRIG   = 3;
    localparam int B_EDGE   = 4;
    localparam int B_DIV    = 5;
    localparam int B_MODE   = 6;
    localparam int B_IE     = 7;

    typedef struct packed {
        logic irq_en;
        logic ext_count;
        logic div_long;
        logic rise_edge;
        logic wait_trig;
    } cfg_t;

    typedef struct packed {
        logic tc_wr;
        logic halt;
    } wr_evt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_st_e;

    function automatic logic [CNT_W-1:0] widen_tc(input logic [BYTE_W-1:0] b);
        if (b == '0)
            return {1'b1, {BYTE_W{1'b0}}};
        return {1'b0, b};
    endfunction

    function automatic logic [PRE_W-1:0] div_last(input logic long_sel);
        return long_sel ? PRE_W'(DIV_LONG - 1) : PRE_W'(DIV_SHORT - 1);
    endfunction

    function automatic cfg_t decode_cfg(input logic [BYTE_W-1:0] b);
        cfg_t c;
        c.irq_en    = b[B_IE];
        c.ext_count = b[B_MODE];
        c.div_long  = b[B_DIV];
        c.rise_edge = b[B_EDGE];
        c.wait_trig = b[B_TRIG];
        return c;
    endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg,
    output wr_evt_t           evt,
    output logic [CNT_W-1:0]  tc_new,
    output logic              tc_seen
);

    logic pend_q;
    logic ctrl_wr;

    always_comb begin
        ctrl_wr   = wr_en & ~pend_q & wr_data[B_CTRL];
        evt.tc_wr = wr_en & pend_q;
        evt.halt  = ctrl_wr & wr_data[B_HALT];
        tc_new    = widen_tc(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            pend_q  <= 1'b0;
            tc_seen <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                cfg    <= decode_cfg(wr_data);
                pend_q <= wr_data[B_FOLLOW];
            end
            if (evt.tc_wr) begin
                pend_q  <= 1'b0;
                tc_seen <= 1'b1;
            end
        end
    end

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.tc_wr |=> !pend_q); // R2

    AST_VECTOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pend_q && !wr_data[B_CTRL]) |=> ($stable(cfg) && $stable(pend_q))); // R1

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic rise_edge,
    output logic det
);

    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;
    logic          cur;
    logic          prv;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[LAST-1:0], ext_in};
    end

    always_comb begin
        cur = sh[LAST-1];
        prv = sh[LAST];
        det = rise_edge ? (cur & ~prv) : (~cur & prv);
    end

    AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (rst)
        det |=> !det); // R6

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic div_long,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = en && (pre_q >= div_last(div_long));

    always_ff @(posedge clk) begin
        if (rst || !en)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    AST_NO_TICK_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick); // R7

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount
    import tmr_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_en,
    input  logic              ext_count,
    input  logic              wait_trig,
    input  wr_evt_t           evt,
    input  logic [CNT_W-1:0]  tc_new,
    input  logic              tc_seen,
    input  logic              det,
    input  logic              tick,
    output logic              pre_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              zero_pulse,
    output logic              irq_req
);

    run_st_e          st_q;
    logic [CNT_W-1:0] tc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             terminal;
    logic [CNT_W-1:0] reload_val;

    always_comb begin
        pre_en     = (st_q == ST_RUN) && !ext_count;
        step       = (st_q == ST_RUN) && !evt.halt && (ext_count ? det : tick);
        terminal   = step && (cnt_q == CNT_W'(1));
        reload_val = evt.tc_wr ? tc_new : tc_q;
        rd_byte    = cnt_q[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            tc_q       <= '0;
            cnt_q      <= '0;
            zero_pulse <= 1'b0;
            irq_req    <= 1'b0;
        end else begin
            zero_pulse <= terminal;
            irq_req    <= terminal & irq_en;
            if (evt.tc_wr)
                tc_q <= tc_new;
            if (evt.halt) begin
                st_q <= ST_IDLE;
            end else if (evt.tc_wr && st_q != ST_RUN) begin
                cnt_q <= tc_new;
                st_q  <= (ext_count || !wait_trig) ? ST_RUN : ST_ARMED;
            end else if (st_q == ST_ARMED && det) begin
                st_q <= ST_RUN;
            end
            if (step)
                cnt_q <= terminal ? reload_val : cnt_q - 1'b1;
        end
    end

    AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |=> !zero_pulse); // R4

    AST_IRQ_WITH_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> zero_pulse); // R4

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        tc_seen |-> (cnt_q != '0 && cnt_q <= CNT_W'(DIV_LONG))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tc_seen |-> !zero_pulse); // R11

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_RUN && !evt.tc_wr) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       ext_in,
    output logic       zero_pulse,
    output logic       irq_req
);

    cfg_t             cfg;
    wr_evt_t          evt;
    logic [CNT_W-1:0] tc_new;
    logic             tc_seen;
    logic             det;
    logic             tick;
    logic             pre_en;

    tmr_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .evt     (evt),
        .tc_new  (tc_new),
        .tc_seen (tc_seen)
    );

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_in),
        .rise_edge (cfg.rise_edge),
        .det       (det)
    );

    tmr_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .en       (pre_en),
        .div_long (cfg.div_long),
        .tick     (tick)
    );

    tmr_downcount u_cnt (
        .clk        (clk),
        .rst        (rst),
        .irq_en     (cfg.irq_en),
        .ext_count  (cfg.ext_count),
        .wait_trig  (cfg.wait_trig),
        .evt        (evt),
        .tc_new     (tc_new),
        .tc_seen    (tc_seen),
        .det        (det),
        .tick       (tick),
        .pre_en     (pre_en),
        .rd_byte    (rd_data),
        .zero_pulse (zero_pulse),
        .irq_req    (irq_req)
    );

endmodule

// File: tb/test_tmr_chan.sv
module test_tmr_chan;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_in = 1'b0;
    logic [7:0] rd_data;
    logic       zero_pulse;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int npulse = 0;
    bit cmp_on = 0;

    // behavioural reference model state
    int m_ie, m_mode, m_big, m_rise, m_trig, m_pend;
    int m_tc, m_cnt, m_run, m_arm, m_pre, m_zero, m_irq;
    int m_s1, m_s2, m_s3;

    tmr_chan i_tmr_chan (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ext_in     (ext_in),
        .zero_pulse (zero_pulse),
        .irq_req    (irq_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int f, ntc, ncnt, nrun, narm, npre, old_ie;
        bit det, tick, en, step, term, ctrlw, tcw, halt;
        cyc++;
        if (rst) begin
            m_ie = 0; m_mode = 0; m_big = 0; m_rise = 0; m_trig = 0; m_pend = 0;
            m_tc = 0; m_cnt = 0; m_run = 0; m_arm = 0; m_pre = 0; m_zero = 0; m_irq = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            ctrlw = wr_en && (m_pend == 0) && wr_data[0];
            tcw   = wr_en && (m_pend != 0);
            halt  = ctrlw && wr_data[1];
            ntc   = (wr_data == 0) ? 256 : int'(wr_data);
            f     = (m_big != 0) ? 256 : 16;
            en    = (m_run != 0) && (m_mode == 0);
            tick  = en && (m_pre >= f - 1);
            det   = (m_rise != 0) ? (m_s2 == 1 && m_s3 == 0) : (m_s2 == 0 && m_s3 == 1);
            step  = (m_run != 0) && !halt && ((m_mode != 0) ? det : tick);
            term  = step && (m_cnt == 1);
            old_ie = m_ie;
            ncnt = m_cnt;
            if (step) ncnt = term ? (tcw ? ntc : m_tc) : m_cnt - 1;
            nrun = m_run; narm = m_arm;
            if (halt) begin
                nrun = 0; narm = 0;
            end else if (tcw && m_run == 0) begin
                ncnt = ntc;
                if (m_mode != 0 || m_trig == 0) begin nrun = 1; narm = 0; end
                else begin nrun = 0; narm = 1; end
            end else if (m_arm != 0 && det) begin
                nrun = 1; narm = 0;
            end
            npre = !en ? 0 : (tick ? 0 : m_pre + 1);
            if (tcw) begin m_tc = ntc; m_pend = 0; end
            if (ctrlw) begin
                m_ie = wr_data[7]; m_mode = wr_data[6]; m_big = wr_data[5];
                m_rise = wr_data[4]; m_trig = wr_data[3]; m_pend = wr_data[2];
            end
            m_zero = term ? 1 : 0;
            m_irq  = (term && old_ie != 0) ? 1 : 0;
            m_cnt = ncnt; m_run = nrun; m_arm = narm; m_pre = npre;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (zero_pulse) npulse++;
        if (cmp_on) begin
            chk(rd_data == 8'(m_cnt), "R3 count", int'(rd_data), m_cnt & 255);
            chk(zero_pulse == m_zero[0], "R4 zero_pulse", int'(zero_pulse), m_zero);
            chk(irq_req == m_irq[0], "R4 irq_req", int'(irq_req), m_irq);
        end
    end

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!zero_pulse);
    endtask

    initial begin
        int p, v, np;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;
        // R12: reset state
        chk(rd_data == 8'h00 && !zero_pulse && !irq_req, "R12 reset state", int'(rd_data), 0);

        // R1, R11: byte with bit0=0 ignored; no constant yet -> idle
        wr(8'h40);
        np = npulse;
        repeat (40) @(negedge clk);
        chk(npulse == np, "R11 idle no pulse", npulse - np, 0);
        chk(rd_data == 8'h00, "R1 ignored byte", int'(rd_data), 0);

        // R8, R7, R4: timer auto start, /16, constant 3, irq enabled
        wr(8'h85);
        wr(8'h03);
        chk(rd_data == 8'd3, "R2 constant loaded", int'(rd_data), 3);
        repeat (15) @(negedge clk);
        chk(rd_data == 8'd3, "R8 before first step", int'(rd_data), 3);
        @(negedge clk);
        chk(rd_data == 8'd2, "R8 first step", int'(rd_data), 2);
        wait_pulse(p);
        wait_pulse(p);
        chk(p == 48, "R7 period /16 x3", p, 48);
        chk(irq_req == 1'b1, "R4 irq with zero", int'(irq_req), 1);
        wr(8'h40);
        wait_pulse(p);
        chk(p == 47, "R1 running ignores vector byte", p, 47);

        // R5: deferred constant while running
        wr(8'h05);
        wr(8'h02);
        chk(rd_data == 8'd3, "R5 no immediate load", int'(rd_data), 3);
        wait_pulse(p);
        wait_pulse(p);
        chk(p == 32, "R5 new constant after reload", p, 32);
        chk(irq_req == 1'b0, "R4 irq masked", int'(irq_req), 0);

        // R3: constant zero means 256
        wr(8'h07);
        wr(8'h00);
        chk(rd_data == 8'h00, "R3 256 reads 0x00", int'(rd_data), 0);
        repeat (16) @(negedge clk);
        chk(rd_data == 8'hFF, "R3 256 then 255", int'(rd_data), 255);

        // R10: software stop and restart
        wr(8'h03);
        v = int'(rd_data);
        np = npulse;
        repeat (50) @(negedge clk);
        chk(int'(rd_data) == v, "R10 count frozen", int'(rd_data), v);
        chk(npulse == np, "R10 no pulse while stopped", npulse - np, 0);
        wr(8'h07);
        wr(8'h05);
        chk(rd_data == 8'd5, "R10 restart value", int'(rd_data), 5);
        wait_pulse(p);
        chk(p == 80, "R10 restart period", p, 80);

        // R6: event counting on rising edges, constant 2
        wr(8'h57);
        wr(8'h02);
        ext_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_data == 8'd1, "R6 rising edge counted", int'(rd_data), 1);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(rd_data == 8'd1, "R6 falling edge ignored", int'(rd_data), 1);
        np = npulse;
        ext_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(npulse - np == 1, "R6 terminal on second edge", npulse - np, 1);
        chk(rd_data == 8'd2, "R4 reload in event mode", int'(rd_data), 2);

        // R9: timer waiting for falling edge on ext_in
        wr(8'h0F);
        wr(8'h04);
        repeat (60) @(negedge clk);
        chk(rd_data == 8'd4, "R9 holds until trigger", int'(rd_data), 4);
        ext_in = 1'b0;
        repeat (18) @(negedge clk);
        chk(rd_data == 8'd4, "R9 not yet stepped", int'(rd_data), 4);
        @(negedge clk);
        chk(rd_data == 8'd3, "R9 first step after trigger", int'(rd_data), 3);

        // R5: constant write landing on the reload cycle
        wr(8'h07);
        wr(8'h01);
        wait_pulse(p);
        wr(8'h05);
        repeat (14) @(negedge clk);
        wr(8'h09);
        chk(rd_data == 8'd9, "R5 coincident write wins", int'(rd_data), 9);
        chk(zero_pulse == 1'b1, "R4 pulse on coincident reload", int'(zero_pulse), 1);

        // R7: divide by 256, constant 2, irq enabled
        wr(8'hA7);
        wr(8'h02);
        wait_pulse(p);
        wait_pulse(p);
        chk(p == 512, "R7 period /256 x2", p, 512);
        chk(irq_req == 1'b1, "R4 irq /256", int'(irq_req), 1);

        // R12: hardware reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(rd_data == 8'h00 && !zero_pulse && !irq_req, "R12 reset mid-run", int'(rd_data), 0);
        np = npulse;
        repeat (600) @(negedge clk);
        chk(npulse == np, "R11 idle after reset", npulse - np, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule